// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers edge-detected interrupt sources into 32-bit source sets and sends them to a processor on two separate request lines. A fixed routing table assigns a small group of sources to numbered priority levels from 1 to 15. Those sources feed a priority encoder. The encoder has its own per-level mask and a global enable, and it drives the high-tier line. Every source that is not in the table uses the low tier instead. There, each bit is gated by its own enable bit, and the gated bits are ORed onto the low-tier line.

Software reaches the block through a small register bus with a one-cycle registered read. Each source set has a status word, a write-ones-to-clear word and an enable word. Set 0 carries no sources. Its address slots hold the summary register (tier flags and vector) and the control register (level mask and global enable). Handler dispatch, timers and peripherals are outside this block.

Top module: `icu_two_tier`

## Requirements
- R1: A source bit's status is set by a qualifying edge on its input and stays set until software clears it. A positive-edge source qualifies on a 0-to-1 transition. A negative-edge source qualifies only on a 1-to-0 transition. The status update happens at the clock edge that first samples the new input level.
- R2: Writing a word to a set's clear slot clears exactly the status bits written as one. All other bits keep their value.
- R3: If a qualifying edge and a clear of the same bit arrive in the same cycle, the bit stays set.
- R4: Source line n belongs to set n/32, bit n%32, and is driven on `src_in[n-32]`. Lines below 32 are invalid. The word address is set*4+slot, with slot 0 = status, slot 1 = clear and slot 2 = enable. Set 0 has no sources: address 0 reads the summary register, address 2 is the control register, and a write to address 1 has no effect on any status bit.
- R5: The fixed level table is as follows. Set 3 bits 25 and 24 → 15. Set 3 bit 30 → 14. Set 3 bit 29 → 13. Set 2 bits 16..19 → 9. Set 2 bits 0..1 → 8. Set 2 bits 20..23 → 7. Set 2 bits 4..5 → 6. Set 1 bit 18 → 4. Set 1 bit 17 → 3. Set 1 bit 27 → 2. Set 3 bits 7 and 0 → 1.
- R6: A level shared by several sources stays active as long as any one of them is pending.
- R7: In the control register, bit 0 is the global enable and bit L (1..15) is the mask bit for level L. `irq_hi` is 1 one cycle after global enable is on and a source is pending at a level whose mask bit is set.
- R8: The summary register places the high-tier-pending flag in bit 31, the low-tier-pending flag in bit 30, and the vector in bits 3:0. The vector is the highest pending level whose mask bit is set, or 0 if there is none. Bit 31 equals (vector != 0), whatever the global enable.
- R9: `irq_lo` (and summary bit 30) is 1 one cycle after any unmapped source is pending with its enable bit set.
- R10: A mapped source never asserts `irq_lo` or summary bit 30, whatever its enable bit.
- R11: After reset, every status, enable, mask and global-enable bit is zero, and both request outputs are low.
- R12: Negative-edge sources have their own status bits and levels. Set 2 bits 20..23 and 4..5, and set 3 bits 24 and 0, are negative-edge sources; all others are positive-edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | (NSETS-1)*32 | Raw source levels, line n on bit n-32 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address, set*4+slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| irq_hi | output | 1 | High-tier request to the processor |
| irq_lo | output | 1 | Low-tier request to the processor |

## Verification
The hardest case to reach from the ports is a status bit that is already set, receiving a clear write and a fresh source edge in the same cycle. To get there, the bench first raises and drops a source so that its bit is pending. It then drives the input high and issues the clear write from the same falling clock edge, so that the edge detector and the clear logic act on the same rising edge. The bench then reads back the status word and expects the bit to still be set. A second case that needs careful ordering is a negative-edge source: the bench holds its input high over several cycles to show that the bit stays clear, and only then lowers it.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int SET_BITS = 32;
  localparam int LVL_W    = 4;
  localparam int NUM_LVL  = 1 << LVL_W;

  // Priority level of a source (0 = low tier)
  function automatic logic [LVL_W-1:0] level_of(input int s, input int b);
    logic [LVL_W-1:0] lv;
    lv = '0;
    case (s)
      1: begin
        if (b == 18)      lv = 4'd4;
        else if (b == 17) lv = 4'd3;
        else if (b == 27) lv = 4'd2;
      end
      2: begin
        if (b >= 16 && b <= 19)      lv = 4'd9;
        else if (b <= 1)             lv = 4'd8;
        else if (b >= 20 && b <= 23) lv = 4'd7;
        else if (b == 4 || b == 5)   lv = 4'd6;
      end
      3: begin
        if (b == 25 || b == 24)   lv = 4'd15;
        else if (b == 30)         lv = 4'd14;
        else if (b == 29)         lv = 4'd13;
        else if (b == 7 || b == 0) lv = 4'd1;
      end
      default: lv = '0;
    endcase
    return lv;
  endfunction

  function automatic logic neg_edge(input int s, input int b);
    return (s == 2 && ((b >= 20 && b <= 23) || b == 4 || b == 5)) ||
           (s == 3 && (b == 24 || b == 0));
  endfunction

  function automatic logic [SET_BITS-1:0] mapped_mask(input int s);
    logic [SET_BITS-1:0] m;
    m = '0;
    for (int b = 0; b < SET_BITS; b++) m[b] = (level_of(s, b) != '0);
    return m;
  endfunction
endpackage

// File: rtl/icu_source_set.sv
module icu_source_set
  import icu_pkg::*;
#(
  parameter int SET_IDX = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_BITS-1:0] src,
  input  logic                clr_we,
  input  logic                en_we,
  input  logic [SET_BITS-1:0] wdata,
  output logic [SET_BITS-1:0] status,
  output logic [SET_BITS-1:0] enable,
  output logic                low_req,
  output logic [NUM_LVL-1:0]  lvl_req
);
  localparam logic [SET_BITS-1:0] MAPPED = mapped_mask(SET_IDX);

  logic [SET_BITS-1:0] src_q;
  logic [SET_BITS-1:0] edge_v;
  logic [SET_BITS-1:0] clr_v;

  for (genvar b = 0; b < SET_BITS; b++) begin : g_edge
    if (neg_edge(SET_IDX, b)) begin : g_neg
      assign edge_v[b] = src_q[b] & ~src[b];
    end else begin : g_pos
      assign edge_v[b] = src[b] & ~src_q[b];
    end
  end

  assign clr_v = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= src;
      status <= '0;
      enable <= '0;
    end else begin
      src_q  <= src;
      status <= (status & ~clr_v) | edge_v;
      if (en_we) enable <= wdata;
    end
  end

  assign low_req = |(status & enable & ~MAPPED);

  always_comb begin
    logic [LVL_W-1:0] lv;
    lvl_req = '0;
    for (int i = 0; i < SET_BITS; i++) begin
      lv = level_of(SET_IDX, i);
      if (lv != '0) lvl_req[lv] = lvl_req[lv] | status[i];
    end
  end

  assert_edge_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (edge_v != '0) |=> ((status & $past(edge_v)) == $past(edge_v)));

  assert_clear_only_ones_R2: assert property (@(posedge clk) disable iff (rst)
    ((clr_v & ~edge_v) != '0) |=> ((status & $past(clr_v & ~edge_v)) == '0));
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc
  import icu_pkg::*;
(
  input  logic [NUM_LVL-1:0] req,
  output logic [LVL_W-1:0]   vec
);
  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (req[i]) vec = LVL_W'(i);
  end
endmodule

// File: rtl/icu_two_tier.sv
module icu_two_tier
  import icu_pkg::*;
#(
  parameter int NSETS  = 4,
  parameter int ADDR_W = $clog2(NSETS) + 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [(NSETS-1)*SET_BITS-1:0] src_in,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          irq_hi,
  output logic                          irq_lo
);
  localparam int SET_W = ADDR_W - 2;
  localparam int NSLOT = 1 << SET_W;
  localparam logic [1:0] SLOT_STAT = 2'd0;
  localparam logic [1:0] SLOT_CLR  = 2'd1;
  localparam logic [1:0] SLOT_EN   = 2'd2;

  logic [SET_W-1:0] a_set;
  logic [1:0]       a_slot;
  assign a_set  = bus_addr[ADDR_W-1:2];
  assign a_slot = bus_addr[1:0];

  logic [SET_BITS-1:0] status_a [NSLOT];
  logic [SET_BITS-1:0] enable_a [NSLOT];
  logic [NUM_LVL-1:0]  lvl_a    [NSLOT];
  logic [NSLOT-1:0]    low_a;

  logic                glb_en;
  logic [NUM_LVL-1:1]  lvl_mask;

  for (genvar s = 0; s < NSLOT; s++) begin : g_set
    if (s == 0 || s >= NSETS) begin : g_none
      assign status_a[s] = '0;
      assign enable_a[s] = '0;
      assign lvl_a[s]    = '0;
      assign low_a[s]    = 1'b0;
    end else begin : g_src
      icu_source_set #(.SET_IDX(s)) u_set (
        .clk     (clk),
        .rst     (rst),
        .src     (src_in[(s-1)*SET_BITS +: SET_BITS]),
        .clr_we  (bus_we && a_set == SET_W'(s) && a_slot == SLOT_CLR),
        .en_we   (bus_we && a_set == SET_W'(s) && a_slot == SLOT_EN),
        .wdata   (bus_wdata),
        .status  (status_a[s]),
        .enable  (enable_a[s]),
        .low_req (low_a[s]),
        .lvl_req (lvl_a[s])
      );
    end
  end

  logic [NUM_LVL-1:0] lvl_any;
  logic [NUM_LVL-1:0] lvl_masked;
  logic [LVL_W-1:0]   vec;
  logic               hi_pend;
  logic               lo_pend;

  always_comb begin
    lvl_any = '0;
    for (int s = 0; s < NSLOT; s++) lvl_any = lvl_any | lvl_a[s];
  end

  assign lvl_masked = lvl_any & {lvl_mask, 1'b0};

  icu_prio_enc u_enc (
    .req (lvl_masked),
    .vec (vec)
  );

  assign hi_pend = (vec != '0);
  assign lo_pend = |low_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en    <= 1'b0;
      lvl_mask  <= '0;
      irq_hi    <= 1'b0;
      irq_lo    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && a_set == '0 && a_slot == SLOT_EN) begin
        glb_en   <= bus_wdata[0];
        lvl_mask <= bus_wdata[NUM_LVL-1:1];
      end
      irq_hi <= glb_en & hi_pend;
      irq_lo <= lo_pend;
      if (a_set == '0) begin
        case (a_slot)
          SLOT_STAT: bus_rdata <= {hi_pend, lo_pend, {(30-LVL_W){1'b0}}, vec};
          SLOT_EN:   bus_rdata <= {{(32-NUM_LVL){1'b0}}, lvl_mask, glb_en};
          default:   bus_rdata <= '0;
        endcase
      end else begin
        case (a_slot)
          SLOT_STAT: bus_rdata <= status_a[a_set];
          SLOT_EN:   bus_rdata <= enable_a[a_set];
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  assert_hi_needs_global_R7: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(glb_en));

  assert_vec_is_active_R8: assert property (@(posedge clk) disable iff (rst)
    (vec != '0) |-> lvl_masked[vec]);

  assert_vec_zero_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (lvl_masked[NUM_LVL-1:1] == '0) |-> (vec == '0));

  assert_lo_follows_R9: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(lo_pend));
endmodule

// File: tb/icu_two_tier_bench.sv
module icu_two_tier_bench;
  localparam int NSETS  = 4;
  localparam int ADDR_W = $clog2(NSETS) + 2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [(NSETS-1)*32-1:0] src = '0;
  logic                    bus_we = 1'b0;
  logic [ADDR_W-1:0]       bus_addr = '0;
  logic [31:0]             bus_wdata = '0;
  logic [31:0]             bus_rdata;
  logic                    irq_hi, irq_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icu_two_tier #(.NSETS(NSETS)) u_icu_two_tier (
    .clk(clk), .rst(rst), .src_in(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  function automatic logic [ADDR_W-1:0] ad(input int set, input int slot);
    return ADDR_W'(set * 4 + slot);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int set, input int slot, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ad(set, slot); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int set, input int slot, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ad(set, slot);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); src[line-32] = 1'b1;
    @(negedge clk); src[line-32] = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq_hi", {31'b0, irq_hi}, 0);
    chk("R11 irq_lo", {31'b0, irq_lo}, 0);
    rd(0, 0, d); chk("R11 summary", d, 0);
    rd(0, 2, d); chk("R11 control", d, 0);
    for (int s = 1; s < NSETS; s++) begin
      rd(s, 0, d); chk("R11 status", d, 0);
      rd(s, 2, d); chk("R11 enable", d, 0);
    end
  endtask

  task automatic t_low();
    logic [31:0] d;
    wr(1, 2, 32'h8);
    pulse(35); pulse(37);
    rd(1, 0, d); chk("R1 low status", d, 32'h28);
    chk("R9 irq_lo set", {31'b0, irq_lo}, 1);
    rd(0, 0, d); chk("R9 summary lo flag", d, 32'h4000_0000);
    wr(1, 1, 32'h8); tick();
    rd(1, 0, d); chk("R2 clear only ones", d, 32'h20);
    chk("R9 irq_lo disabled bit", {31'b0, irq_lo}, 0);
    wr(1, 1, 32'h20);
    rd(1, 0, d); chk("R2 clear rest", d, 0);
  endtask

  task automatic t_mapped();
    logic [31:0] d;
    wr(1, 2, 32'hFFFF_FFFF);
    pulse(50);
    tick();
    chk("R10 irq_lo mapped", {31'b0, irq_lo}, 0);
    rd(1, 0, d); chk("R10 mapped status", d, 32'h0004_0000);
    rd(0, 0, d); chk("R10 R8 summary masked", d, 0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(0, 2, 32'h10); tick();
    rd(0, 0, d); chk("R8 vector without global", d, 32'h8000_0004);
    chk("R7 irq_hi off without global", {31'b0, irq_hi}, 0);
    wr(0, 2, 32'h11); tick();
    chk("R7 irq_hi on", {31'b0, irq_hi}, 1);
    wr(1, 1, 32'h0004_0000); tick();
    chk("R7 irq_hi after clear", {31'b0, irq_hi}, 0);
    rd(0, 0, d); chk("R8 summary idle", d, 0);
    wr(1, 2, 0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    wr(0, 2, 32'hFFFF);
    pulse(125); pulse(121); pulse(49);
    rd(0, 0, d); chk("R5 top level 15", d, 32'h8000_000F);
    wr(3, 1, 32'h0200_0000);
    rd(0, 0, d); chk("R5 periodic level 13", d, 32'h8000_000D);
    wr(0, 2, 32'hFFFF & ~32'h2000);
    rd(0, 0, d); chk("R7 mask drops level 13", d, 32'h8000_0003);
    chk("R7 irq_hi with level 3", {31'b0, irq_hi}, 1);
    wr(0, 2, 32'hFFFF);
    wr(3, 1, 32'h2000_0000); wr(1, 1, 32'h0002_0000); tick();
    chk("R7 irq_hi idle", {31'b0, irq_hi}, 0);
    pulse(126);
    rd(3, 0, d); chk("R4 alarm line address", d, 32'h4000_0000);
    rd(0, 0, d); chk("R5 alarm level 14", d, 32'h8000_000E);
    wr(3, 1, 32'h4000_0000);
    rd(0, 0, d); chk("R8 vector zero", d, 0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    pulse(80); pulse(83);
    rd(0, 0, d); chk("R6 shared level 9", d, 32'h8000_0009);
    wr(2, 1, 32'h0001_0000);
    rd(0, 0, d); chk("R6 level held by peer", d, 32'h8000_0009);
    wr(2, 1, 32'h0008_0000);
    rd(0, 0, d); chk("R6 level released", d, 0);
  endtask

  task automatic t_neg();
    logic [31:0] d;
    @(negedge clk); src[84-32] = 1'b1;
    tick(); tick(); tick();
    rd(2, 0, d); chk("R12 rise ignored", d, 0);
    @(negedge clk); src[84-32] = 1'b0;
    tick(); tick();
    rd(2, 0, d); chk("R12 fall captured", d, 32'h0010_0000);
    rd(0, 0, d); chk("R12 negative level 7", d, 32'h8000_0007);
    wr(2, 1, 32'h0010_0000);
  endtask

  task automatic t_set0();
    logic [31:0] d;
    pulse(80);
    wr(0, 1, 32'hFFFF_FFFF);
    rd(2, 0, d); chk("R4 set0 clear no effect", d, 32'h0001_0000);
    wr(0, 0, 32'h0);
    rd(0, 2, d); chk("R4 summary write no effect", d, 32'hFFFF);
    wr(2, 1, 32'h0001_0000);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(80);
    @(negedge clk);
    src[80-32] = 1'b1;
    bus_we = 1'b1; bus_addr = ad(2, 1); bus_wdata = 32'h0001_0000;
    @(negedge clk);
    bus_we = 1'b0; src[80-32] = 1'b0;
    rd(2, 0, d); chk("R3 edge wins over clear", d, 32'h0001_0000);
    wr(2, 1, 32'h0001_0000);
    rd(2, 0, d); chk("R3 later clear works", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_low();
    t_mapped();
    t_gate();
    t_levels();
    t_shared();
    t_neg();
    t_set0();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule